// File: doc/BRIEF.md
# Debug Serial Port with CPU Debug Request

This block is a serial debug port that lives entirely in the processor clock domain. Its serial clock, mode-select and data inputs are slow asynchronous signals. Each one is passed through a synchronizer, and the edges of the serial clock are found by comparing successive synchronized samples. A rising serial-clock edge moves a sixteen-state test access controller and samples the serial data input. A falling edge updates the serial output and its output enable. The enable is high only while an instruction or data register is being shifted.

The port holds an 8-bit instruction register and a 32-bit data register that belongs to the debug block. The all-ones instruction selects a 1-bit bypass stage. One instruction code asks the CPU to stop for debugging. Loading that code raises a debug request. The request stays high until the CPU acknowledges that it has entered debug mode, and while it is high it also drives a wake indication that takes the core out of its low-power modes. Any other instruction reaches only the block's own data register, so it leaves the CPU running.

The controller states are RESET, IDLE, SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR, SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR and UPD_IR. The transitions below are written "mode-select low / mode-select high":

| State | Next when low | Next when high |
|---|---|---|
| RESET | IDLE | RESET |
| IDLE | IDLE | SEL_DR |
| SEL_DR | CAP_DR | SEL_IR |
| SEL_IR | CAP_IR | RESET |
| CAP_DR, SHF_DR | SHF_DR | EX1_DR |
| EX1_DR | PAU_DR | UPD_DR |
| PAU_DR | PAU_DR | EX2_DR |
| EX2_DR | SHF_DR | UPD_DR |
| UPD_DR, UPD_IR | IDLE | SEL_DR |

The IR-side states CAP_IR through EX2_IR follow the same pattern as their DR-side counterparts.

Top module: `dbg_serial_port`

## Requirements
- R1: When the asynchronous reset is low, the controller goes to RESET, the instruction register becomes all ones (bypass), the data register becomes 0, and tdo_oe, dbg_req and wake are all 0.
- R2: The controller changes state only on a synchronized rising serial-clock edge, following the table above. Five rising edges with mode-select high reach RESET from any state, and RESET reloads the all-ones instruction.
- R3: On a rising edge in SHF_IR or SHF_DR, the selected shift register moves one place toward its LSB and the sampled data input enters at its MSB. Serial input is therefore least significant bit first.
- R4: tdo and tdo_oe change only on a synchronized falling serial-clock edge. In a shift state, tdo then takes bit 0 of the selected register, so output is least significant bit first.
- R5: At each falling edge, tdo_oe becomes 1 if the controller is in SHF_IR or SHF_DR and 0 otherwise.
- R6: A rising edge in CAP_IR loads the instruction shift register with 8'b0000_0001, so the first bit scanned out of an instruction scan is 1.
- R7: The all-ones instruction selects a 1-bit bypass stage that captures 0. Any other instruction selects the 32-bit data register. It loads the held value at CAP_DR, and the held value takes the shifted value at UPD_DR.
- R8: A rising edge in UPD_IR with the shifted instruction equal to 8'h07 sets dbg_req. Updates with other codes, and data-register scans, never set it.
- R9: dbg_req stays 1 until cpu_dbg_ack is 1 at a clock edge, and it clears on that edge. A set on the same edge wins. cpu_dbg_ack has no effect while dbg_req is 0.
- R10: wake is 1 whenever dbg_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tclk_in | input | 1 | Serial clock, asynchronous, at most half of clk |
| tms_in | input | 1 | Mode select, asynchronous |
| tdi_in | input | 1 | Serial data in, asynchronous |
| cpu_dbg_ack | input | 1 | CPU has entered debug mode |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Output enable for tdo |
| dbg_req | output | 1 | Debug request to the CPU |
| wake | output | 1 | Wake from stop, doze or wait mode |

## Verification
The bench builds the block with its default parameters: an 8-bit instruction, a 32-bit data register, two synchronizer stages and request code 8'h07. With these, full instruction and data scans are short enough to run many times. The bench holds each serial-clock phase for six processor clocks, which leaves room for the synchronizer and edge-detect latency. It can therefore check that tdo stays still through a high phase and moves only after a falling edge. The short instruction width also makes it cheap to load the request code, hold it against a missing acknowledge, and cut it with a mid-run asynchronous reset.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

    typedef enum logic [3:0] {
        TAP_RESET,
        TAP_IDLE,
        TAP_SEL_DR,
        TAP_CAP_DR,
        TAP_SHF_DR,
        TAP_EX1_DR,
        TAP_PAU_DR,
        TAP_EX2_DR,
        TAP_UPD_DR,
        TAP_SEL_IR,
        TAP_CAP_IR,
        TAP_SHF_IR,
        TAP_EX1_IR,
        TAP_PAU_IR,
        TAP_EX2_IR,
        TAP_UPD_IR
    } tap_state_e;

    typedef struct packed {
        logic in_reset;
        logic cap_ir;
        logic shf_ir;
        logic upd_ir;
        logic cap_dr;
        logic shf_dr;
        logic upd_dr;
    } tap_ctl_t;

endpackage

// File: rtl/dbgp_sync.sv
module dbgp_sync #(
    parameter int N_SIG  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] d,
    output logic [N_SIG-1:0] q
);

    localparam int LAST = STAGES - 1;

    // One synchronizer chain per input signal.
    for (genvar g = 0; g < N_SIG; g++) begin : g_chain
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], d[g]};
            end
        end
        assign q[g] = chain[LAST];
    end

endmodule

// File: rtl/dbgp_tap_fsm.sv
module dbgp_tap_fsm
    import dbgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       tms,
    output tap_state_e state,
    output tap_ctl_t   ctl
);

    tap_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            TAP_RESET:  nxt = tms ? TAP_RESET  : TAP_IDLE;
            TAP_IDLE:   nxt = tms ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_DR: nxt = tms ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: nxt = tms ? TAP_EX1_DR : TAP_SHF_DR;
            TAP_SHF_DR: nxt = tms ? TAP_EX1_DR : TAP_SHF_DR;
            TAP_EX1_DR: nxt = tms ? TAP_UPD_DR : TAP_PAU_DR;
            TAP_PAU_DR: nxt = tms ? TAP_EX2_DR : TAP_PAU_DR;
            TAP_EX2_DR: nxt = tms ? TAP_UPD_DR : TAP_SHF_DR;
            TAP_UPD_DR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
            TAP_SEL_IR: nxt = tms ? TAP_RESET  : TAP_CAP_IR;
            TAP_CAP_IR: nxt = tms ? TAP_EX1_IR : TAP_SHF_IR;
            TAP_SHF_IR: nxt = tms ? TAP_EX1_IR : TAP_SHF_IR;
            TAP_EX1_IR: nxt = tms ? TAP_UPD_IR : TAP_PAU_IR;
            TAP_PAU_IR: nxt = tms ? TAP_EX2_IR : TAP_PAU_IR;
            TAP_EX2_IR: nxt = tms ? TAP_UPD_IR : TAP_SHF_IR;
            TAP_UPD_IR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
            default:    nxt = TAP_RESET;
        endcase
    end

    // State register: advances only on a detected serial-clock rise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TAP_RESET;
        end else if (adv) begin
            state <= nxt;
        end
    end

    // Output decode.
    always_comb begin
        ctl          = '0;
        ctl.in_reset = (state == TAP_RESET);
        ctl.cap_ir   = (state == TAP_CAP_IR);
        ctl.shf_ir   = (state == TAP_SHF_IR);
        ctl.upd_ir   = (state == TAP_UPD_IR);
        ctl.cap_dr   = (state == TAP_CAP_DR);
        ctl.shf_dr   = (state == TAP_SHF_DR);
        ctl.upd_dr   = (state == TAP_UPD_DR);
    end

endmodule

// File: rtl/dbgp_regs.sv
module dbgp_regs
    import dbgp_pkg::*;
#(
    parameter int IR_W = 8,
    parameter int DR_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise,
    input  logic            fall,
    input  logic            tdi,
    input  tap_ctl_t        ctl,
    output logic [IR_W-1:0] ir_shift,
    output logic            tdo,
    output logic            tdo_oe
);

    localparam logic [IR_W-1:0] BYPASS_CODE = '1;
    localparam logic [IR_W-1:0] IR_CAPTURE  = {{(IR_W-1){1'b0}}, 1'b1};

    logic [IR_W-1:0] ir_hold;
    logic [DR_W-1:0] dr_shift;
    logic [DR_W-1:0] dr_hold;
    logic            byp_bit;
    logic            sel_byp;
    logic            out_bit;

    assign sel_byp = (ir_hold == BYPASS_CODE);

    always_comb begin
        if (ctl.shf_ir) begin
            out_bit = ir_shift[0];
        end else if (ctl.shf_dr) begin
            out_bit = sel_byp ? byp_bit : dr_shift[0];
        end else begin
            out_bit = 1'b0;
        end
    end

    // Instruction path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_shift <= '0;
            ir_hold  <= BYPASS_CODE;
        end else if (rise) begin
            if (ctl.cap_ir) begin
                ir_shift <= IR_CAPTURE;
            end else if (ctl.shf_ir) begin
                ir_shift <= {tdi, ir_shift[IR_W-1:1]};
            end
            if (ctl.in_reset) begin
                ir_hold <= BYPASS_CODE;
            end else if (ctl.upd_ir) begin
                ir_hold <= ir_shift;
            end
        end
    end

    // Data and bypass path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_shift <= '0;
            dr_hold  <= '0;
            byp_bit  <= 1'b0;
        end else if (rise) begin
            if (ctl.cap_dr) begin
                if (sel_byp) begin
                    byp_bit <= 1'b0;
                end else begin
                    dr_shift <= dr_hold;
                end
            end else if (ctl.shf_dr) begin
                if (sel_byp) begin
                    byp_bit <= tdi;
                end else begin
                    dr_shift <= {tdi, dr_shift[DR_W-1:1]};
                end
            end
            if (ctl.upd_dr && !sel_byp) begin
                dr_hold <= dr_shift;
            end
        end
    end

    // Serial output moves on falling serial-clock edges only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (fall) begin
            tdo    <= out_bit;
            tdo_oe <= ctl.shf_ir | ctl.shf_dr;
        end
    end

endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
    import dbgp_pkg::*;
#(
    parameter int              IR_W        = 8,
    parameter int              DR_W        = 32,
    parameter int              SYNC_STAGES = 2,
    parameter logic [IR_W-1:0] REQ_CODE    = 8'h07
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tclk_in,
    input  logic tms_in,
    input  logic tdi_in,
    input  logic cpu_dbg_ack,
    output logic tdo,
    output logic tdo_oe,
    output logic dbg_req,
    output logic wake
);

    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] sync_out;
    logic              tclk_s;
    logic              tms_s;
    logic              tdi_s;
    logic              tclk_prev;
    logic              tclk_rise;
    logic              tclk_fall;
    logic              req_set;
    logic [IR_W-1:0]   ir_shift;
    tap_state_e        state;
    tap_ctl_t          ctl;

    assign raw_in = {tdi_in, tms_in, tclk_in};

    dbgp_sync #(
        .N_SIG  (N_SYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    assign tclk_s = sync_out[0];
    assign tms_s  = sync_out[1];
    assign tdi_s  = sync_out[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tclk_prev <= 1'b0;
        end else begin
            tclk_prev <= tclk_s;
        end
    end

    assign tclk_rise = tclk_s & ~tclk_prev;
    assign tclk_fall = ~tclk_s & tclk_prev;

    dbgp_tap_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tclk_rise),
        .tms   (tms_s),
        .state (state),
        .ctl   (ctl)
    );

    dbgp_regs #(
        .IR_W (IR_W),
        .DR_W (DR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (tclk_rise),
        .fall     (tclk_fall),
        .tdi      (tdi_s),
        .ctl      (ctl),
        .ir_shift (ir_shift),
        .tdo      (tdo),
        .tdo_oe   (tdo_oe)
    );

    // Debug request: set by the update of the request instruction and held
    // until the CPU acknowledges. A set on the same edge wins.
    assign req_set = tclk_rise & ctl.upd_ir & (ir_shift == REQ_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbg_req <= 1'b0;
        end else if (req_set) begin
            dbg_req <= 1'b1;
        end else if (cpu_dbg_ack) begin
            dbg_req <= 1'b0;
        end
    end

    assign wake = dbg_req;

endmodule

// File: rtl/dbgp_chk.sv
module dbgp_chk
    import dbgp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tclk_rise,
    input logic       tclk_fall,
    input tap_state_e state,
    input logic       tdo,
    input logic       tdo_oe,
    input logic       dbg_req,
    input logic       cpu_dbg_ack,
    input logic       req_set
);

    // R2
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tclk_rise |=> $stable(state));

    // R4
    tdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tclk_fall |=> ($stable(tdo) && $stable(tdo_oe)));

    // R5
    oe_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tdo_oe) |-> $past(state == TAP_SHF_IR || state == TAP_SHF_DR));

    // R8
    req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_req) |-> $past(state == TAP_UPD_IR && tclk_rise));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !cpu_dbg_ack) |=> dbg_req);

    // R9
    req_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && cpu_dbg_ack && !req_set) |=> !dbg_req);

endmodule

bind dbg_serial_port dbgp_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tclk_rise   (tclk_rise),
    .tclk_fall   (tclk_fall),
    .state       (state),
    .tdo         (tdo),
    .tdo_oe      (tdo_oe),
    .dbg_req     (dbg_req),
    .cpu_dbg_ack (cpu_dbg_ack),
    .req_set     (req_set)
);

// File: tb/sim_dbg_serial_port.sv
`timescale 1ns/1ps
module sim_dbg_serial_port;

    localparam int HALF  = 6;
    localparam int NVEC  = 5;
    localparam logic [31:0] DR_VEC [NVEC] = '{
        32'hDEADBEEF, 32'h00000001, 32'h80000000, 32'hA5A5A5A5, 32'h12345678
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tclk = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic ack = 1'b0;
    logic tdo, tdo_oe, dbg_req, wake;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dbg_serial_port u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tclk_in     (tclk),
        .tms_in      (tms),
        .tdi_in      (tdi),
        .cpu_dbg_ack (ack),
        .tdo         (tdo),
        .tdo_oe      (tdo_oe),
        .dbg_req     (dbg_req),
        .wake        (wake)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tck(input logic tms_v, input logic tdi_v);
        @(negedge clk);
        tms  = tms_v;
        tdi  = tdi_v;
        tclk = 1'b1;
        repeat (HALF) @(negedge clk);
        tclk = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    // From IDLE: scan n bits, return the bits seen on tdo, end in IDLE.
    task automatic scan(input bit is_ir, input int n, input logic [63:0] din,
                        output logic [63:0] dout);
        dout = '0;
        tck(1'b1, 1'b0);
        if (is_ir) tck(1'b1, 1'b0);
        tck(1'b0, 1'b0);
        tck(1'b0, 1'b0);
        check("R5 oe in shift", {63'd0, tdo_oe}, 64'd1);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tck(i == n - 1, din[i]);
        end
        check("R5 oe after shift", {63'd0, tdo_oe}, 64'd0);
        tck(1'b1, 1'b0);
        tck(1'b0, 1'b0);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] got;
        logic [31:0] prev;
        logic        held;

        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 oe", {63'd0, tdo_oe}, 64'd0);
        check("R1 req", {63'd0, dbg_req}, 64'd0);
        check("R10 wake", {63'd0, wake}, 64'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        tck(1'b0, 1'b0);

        // R7 bypass after reset: one-bit delay, captured 0 first
        scan(1'b0, 8, 64'hA5, got);
        check("R7 R1 bypass", got, 64'h4A);

        // R6 instruction capture value, R8 other code raises no request
        scan(1'b1, 8, 64'h02, got);
        check("R6 ir capture", got, 64'h01);
        check("R8 no req for code 02", {63'd0, dbg_req}, 64'd0);

        // R3 R7 table of data-register patterns
        prev = 32'h0;
        for (int v = 0; v < NVEC; v++) begin
            scan(1'b0, 32, {32'd0, DR_VEC[v]}, got);
            check("R3 R7 dr readback", got, {32'd0, prev});
            prev = DR_VEC[v];
        end
        check("R8 dr scans no req", {63'd0, dbg_req}, 64'd0);

        // R4 tdo steady through a high phase in Shift-DR
        tck(1'b1, 1'b0);
        tck(1'b0, 1'b0);
        tck(1'b0, 1'b0);
        held = tdo;
        @(negedge clk);
        tms  = 1'b0;
        tdi  = ~held;
        tclk = 1'b1;
        repeat (HALF) @(negedge clk);
        check("R4 tdo stable while high", {63'd0, tdo}, {63'd0, held});
        tclk = 1'b0;
        repeat (HALF) @(negedge clk);
        check("R4 tdo next lsb after fall", {63'd0, tdo}, {63'd0, prev[1]});

        // R2 five TMS-high edges reach RESET; bypass reloaded
        repeat (5) tck(1'b1, 1'b0);
        check("R2 oe off in reset", {63'd0, tdo_oe}, 64'd0);
        tck(1'b0, 1'b0);
        scan(1'b0, 8, 64'h3C, got);
        check("R2 bypass after tms reset", got, 64'h78);

        // R9 ack with no request has no effect
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        check("R9 ack alone", {63'd0, dbg_req}, 64'd0);

        // R8 request instruction, R10 wake
        scan(1'b1, 8, 64'h07, got);
        check("R8 req set", {63'd0, dbg_req}, 64'd1);
        check("R10 wake with req", {63'd0, wake}, 64'd1);
        repeat (20) @(negedge clk);
        check("R9 req held", {63'd0, dbg_req}, 64'd1);
        ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        check("R9 req cleared by ack", {63'd0, dbg_req}, 64'd0);
        check("R10 wake cleared", {63'd0, wake}, 64'd0);
        scan(1'b0, 32, 64'h55AA, got);
        check("R8 no re-raise on dr scan", {63'd0, dbg_req}, 64'd0);

        // R1 asynchronous reset cuts a pending request
        scan(1'b1, 8, 64'h07, got);
        check("R8 req set again", {63'd0, dbg_req}, 64'd1);
        #1 rst_n = 1'b0;
        #1;
        check("R1 async req clear", {63'd0, dbg_req}, 64'd0);
        check("R1 async oe clear", {63'd0, tdo_oe}, 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        tck(1'b0, 1'b0);
        scan(1'b0, 8, 64'hF0, got);
        check("R1 bypass after async reset", got, 64'hE0);

        summary();
        $finish;
    end

endmodule